// File: doc/BRIEF.md
# Fixed-Priority DMA Channel Arbiter

This block decides which of eight DMA channels may drive a shared bus master. A channel shows that it wants service by raising its active line. Every channel also presents the size of the group of words it would hand to the master if granted. When no grant is held, the arbiter picks the active channel with the smallest index. Index 0 wins over everything, and index 7 loses to everything. The arbiter then loads that channel's group size into a counter.

While a grant is held, nothing can take it away. A higher-priority channel that becomes active must wait. A granted channel that drops its active line keeps the grant. Only the master's per-word completion pulses count the group down. When the last pulse arrives, the grant is released. The next choice is made in the cycle that follows the release.

The per-channel interrupt requests are merged into a single interrupt line for the interrupt controller.

Top module: `dma_chan_arbiter`

## Requirements
- R1: While reset is low, and after it is released with no channel active, no grant is asserted and busy is low.
- R2: The grant vector has at most one bit set in every cycle.
- R3: When no grant is held and at least one channel is active at a clock edge, the lowest-indexed active channel is granted from the next cycle on.
- R4: The grant stays on the same channel until the master has pulsed word_done once per word of the group. A word_done pulse while no grant is held has no effect.
- R5: A higher-priority channel that becomes active while another channel holds the grant does not take the grant before the current group has finished.
- R6: A granted channel that deasserts its active line mid-group keeps the grant until its group has finished.
- R7: The cycle after the final word_done of a group, no grant is asserted. If a channel is active in that cycle, the new grant appears one cycle later.
- R8: Channel i's group size is read from ch_words bits [2i+1:2i] at the edge where the grant is decided. A field value n means n+1 words, so 0 means 1 word and 3 means 4 words.
- R9: irq is high in exactly the cycles in which at least one ch_irq bit is high, with no register delay.
- R10: busy is high exactly when a grant bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_active | input | 8 | Per-channel service request |
| ch_words | input | 16 | Per-channel group size, 2 bits each, value n means n+1 words |
| word_done | input | 1 | One pulse per word completed by the master |
| ch_irq | input | 8 | Per-channel interrupt requests |
| grant | output | 8 | One-hot grant to the channel that owns the master |
| busy | output | 1 | A group is in flight |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach is a change in channel demand while a group is only partly done. This covers a higher-priority channel arriving, the owner withdrawing, and stray completion pulses while idle. In each case the grant must stay put until the exact final pulse. Directed sequences hold a group open by spacing the word_done pulses apart. While the group is open, they raise channel 1 against channel 5 and then drop channel 5. A long random phase then mixes group sizes, sparse and dense pulses, and changing demand. A behavioural model predicts the grant, busy and irq in every cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_OWNED = 1'b1
    } arb_phase_e;

endpackage

// File: rtl/dma_arb_prio_pick.sv
module dma_arb_prio_pick #(
    parameter int unsigned NUM_CH = 8,
    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] pick_onehot,
    output logic [IDX_W-1:0]  pick_idx,
    output logic              pick_any
);

    logic [NUM_CH:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chain
        assign pick_onehot[g] = req[g] & ~seen[g];
        assign seen[g+1]      = seen[g] | req[g];
    end

    assign pick_any = seen[NUM_CH];

    always_comb begin
        pick_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dma_arb_group_ctr.sv
module dma_arb_group_ctr #(
    parameter int unsigned MAX_GROUP = 4,
    localparam int unsigned CNT_W = $clog2(MAX_GROUP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] remaining,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign remaining = cnt_q;
    assign last      = (cnt_q == CNT_W'(1));

    // R4: completion pulses are only counted while words remain
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));

    // R8: a load never exceeds the largest group
    a_r8_load_range: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val >= CNT_W'(1) && load_val <= CNT_W'(MAX_GROUP)));

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_arb_pkg::*;
#(
    parameter int unsigned NUM_CH    = 8,
    parameter int unsigned MAX_GROUP = 4,
    localparam int unsigned FLD_W = (MAX_GROUP > 1) ? $clog2(MAX_GROUP) : 1,
    localparam int unsigned CNT_W = $clog2(MAX_GROUP + 1),
    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       ch_active,
    input  logic [NUM_CH*FLD_W-1:0] ch_words,
    input  logic                    word_done,
    input  logic [NUM_CH-1:0]       ch_irq,
    output logic [NUM_CH-1:0]       grant,
    output logic                    busy,
    output logic                    irq
);

    typedef struct packed {
        arb_phase_e        phase;
        logic [NUM_CH-1:0] grant;
    } arb_state_t;

    arb_state_t st_d;
    arb_state_t st_q;

    logic [NUM_CH-1:0] pick_onehot;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_any;
    logic [FLD_W-1:0]  sel_field;
    logic [CNT_W-1:0]  load_val;
    logic [CNT_W-1:0]  remaining;
    logic              last_word;
    logic              start_grp;
    logic              count_word;
    logic              finish_grp;

    dma_arb_prio_pick #(
        .NUM_CH (NUM_CH)
    ) u_pick (
        .req         (ch_active),
        .pick_onehot (pick_onehot),
        .pick_idx    (pick_idx),
        .pick_any    (pick_any)
    );

    assign sel_field = ch_words[pick_idx*FLD_W +: FLD_W];
    assign load_val  = CNT_W'(sel_field) + CNT_W'(1);

    assign start_grp  = (st_q.phase == ARB_IDLE) && pick_any;
    assign count_word = (st_q.phase == ARB_OWNED) && word_done;
    assign finish_grp = count_word && last_word;

    dma_arb_group_ctr #(
        .MAX_GROUP (MAX_GROUP)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_grp),
        .load_val  (load_val),
        .dec       (count_word),
        .remaining (remaining),
        .last      (last_word)
    );

    always_comb begin
        st_d = st_q;
        if (start_grp) begin
            st_d.phase = ARB_OWNED;
            st_d.grant = pick_onehot;
        end else if (finish_grp) begin
            st_d.phase = ARB_IDLE;
            st_d.grant = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: ARB_IDLE, grant: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign grant = st_q.grant;
    assign busy  = (st_q.phase == ARB_OWNED);
    assign irq   = |ch_irq;

    // R2: never more than one owner
    a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R10: busy matches presence of a grant
    a_r10_busy_grant: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (grant != '0));

    // R3: channel 0 wins whenever the master is free
    a_r3_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ch_active[0]) |=> grant[0]);

    // R5 / R6: no change of owner before the group ends
    a_r5_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(word_done && remaining == CNT_W'(1))) |=> $stable(grant));

    // R7: the final word frees the master for one cycle
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && word_done && remaining == CNT_W'(1)) |=> !busy);

endmodule

// File: tb/dma_chan_arbiter_tb.sv
`timescale 1ns/1ps
module dma_chan_arbiter_tb;

    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ch_active = '0;
    logic [15:0] ch_words = '0;
    logic        word_done = 1'b0;
    logic [7:0]  ch_irq = '0;
    logic [7:0]  grant;
    logic        busy;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string phase_tag = "R1";

    int ref_owner = -1;
    int ref_left = 0;

    always #10 clk = ~clk;

    dma_chan_arbiter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_active (ch_active),
        .ch_words  (ch_words),
        .word_done (word_done),
        .ch_irq    (ch_irq),
        .grant     (grant),
        .busy      (busy),
        .irq       (irq)
    );

    // behavioural reference: owner index and words left
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_owner = -1;
            ref_left  = 0;
        end else if (ref_owner < 0) begin
            for (int i = NCH - 1; i >= 0; i--) begin
                if (ch_active[i]) ref_owner = i;
            end
            if (ref_owner >= 0) ref_left = ch_words[2*ref_owner +: 2] + 1;
        end else if (word_done) begin
            ref_left = ref_left - 1;
            if (ref_left == 0) ref_owner = -1;
        end
    end

    function automatic logic [7:0] exp_grant();
        return (ref_owner < 0) ? 8'h00 : (8'h01 << ref_owner);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        check({phase_tag, " grant"}, 32'(grant), 32'(exp_grant()));
        check("R10 busy", 32'(busy), 32'(ref_owner >= 0));
        check("R9 irq", 32'(irq), 32'(|ch_irq));
        check("R2 onehot", 32'($countones(grant) <= 1), 32'd1);
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual %0d expected < 100000 cycles", cycles);
            summary();
        end
    end

    task automatic drive(input logic [7:0] act, input logic [15:0] wds,
                         input logic done, input logic [7:0] irqs);
        @(posedge clk);
        #2;
        ch_active = act;
        ch_words  = wds;
        word_done = done;
        ch_irq    = irqs;
    endtask

    initial begin
        // R1: reset state
        phase_tag = "R1";
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        drive(8'h00, 16'h0000, 1'b0, 8'h00);
        drive(8'h00, 16'h0000, 1'b0, 8'h00);

        // R4: stray pulses while idle
        phase_tag = "R4 idle";
        drive(8'h00, 16'hFFFF, 1'b1, 8'h10);
        drive(8'h00, 16'hFFFF, 1'b1, 8'h00);

        // R3 + R8: channel 5 alone, field 2 -> 3 words
        phase_tag = "R3";
        drive(8'h20, 16'h0800, 1'b0, 8'h00);
        drive(8'h20, 16'h0800, 1'b0, 8'h00);
        @(negedge clk) check("R3 ch5 granted", 32'(grant), 32'h20);

        // R5: channel 1 arrives mid-group
        phase_tag = "R5";
        drive(8'h22, 16'h0800, 1'b1, 8'h02);
        drive(8'h22, 16'h0800, 1'b0, 8'h00);
        @(negedge clk) check("R5 ch5 kept", 32'(grant), 32'h20);

        // R6: channel 5 withdraws, still owns
        phase_tag = "R6";
        drive(8'h02, 16'h0800, 1'b1, 8'h00);
        drive(8'h02, 16'h0800, 1'b0, 8'h00);
        @(negedge clk) check("R6 ch5 kept", 32'(grant), 32'h20);

        // R7: final word, one free cycle, then channel 1
        phase_tag = "R7";
        drive(8'h02, 16'h0800, 1'b1, 8'h00);
        drive(8'h02, 16'h0800, 1'b0, 8'h00);
        @(negedge clk) check("R7 released", 32'(grant), 32'h00);
        drive(8'h02, 16'h0800, 1'b0, 8'h00);
        @(negedge clk) check("R7 ch1 granted", 32'(grant), 32'h02);
        drive(8'h00, 16'h0800, 1'b1, 8'h00);
        drive(8'h00, 16'h0000, 1'b0, 8'h00);

        // R8: channel 0 vs 7, field 3 = 4 words; then field 0 = 1 word
        phase_tag = "R8";
        drive(8'h81, 16'hC003, 1'b0, 8'h80);
        for (int k = 0; k < 4; k++) drive(8'h81, 16'hC003, 1'b1, 8'h00);
        drive(8'h80, 16'h0003, 1'b0, 8'h00);
        drive(8'h80, 16'h0003, 1'b0, 8'h00);
        @(negedge clk) check("R8 ch7 granted", 32'(grant), 32'h80);
        drive(8'h00, 16'h0003, 1'b1, 8'h00);
        drive(8'h00, 16'h0003, 1'b0, 8'h00);
        @(negedge clk) check("R8 one word done", 32'(grant), 32'h00);

        // random mix: R3 R4 R5 R6 R7 R9
        phase_tag = "R3/R5/R7 random";
        for (int k = 0; k < 4000; k++) begin
            drive(8'($urandom), 16'($urandom), 1'($urandom_range(0, 2) == 0),
                  8'($urandom) & 8'($urandom));
        end
        drive(8'h00, 16'h0000, 1'b0, 8'h00);
        @(negedge clk);
        #1 summary();
    end

endmodule